// File: doc/BRIEF.md
# Ring Switch Node With Source Queue

This block is one stop on a unidirectional on-chip ring. It has two input links and two output links. One input and one output face the upstream and downstream ring neighbours. The other input and output face a local device, which may issue requests, answer them, or do both. Every link carries a single-word flit and uses a valid/ready handshake. A transfer happens in a cycle where both valid and ready are high.

Each flit holds a destination node number in its top `ID_W` bits. The bit below that is a response flag (1 for response, 0 for request). The low `PAY_W` bits are payload. A flit arriving on the ring whose destination equals the node's own `NODE_ID` leaves the ring through the local output. Every other arriving flit is passed downstream unchanged, in the same cycle.

The local device injects flits into a small first-in first-out source queue. The queue head competes for the downstream link, and traffic already on the ring always wins that contest. Arbitration is purely local. Requests and responses share the links as independent flits. The node never looks at the response flag.

Top module: `ring_node`

## Requirements
- R1: After reset, the source queue is empty: `ringOutValid` and `locOutValid` are low while `ringInValid` is low, and `locInReady` is high.
- R2: A valid ring flit whose destination field (bits `[FLIT_W-1 -: ID_W]`) equals `NODE_ID` is presented on `locOutData` with `locOutValid` high in the same cycle. It is not offered as transit traffic on the ring output.
- R3: A valid ring flit whose destination differs from `NODE_ID` is presented unchanged on `ringOutData` with `ringOutValid` high in the same cycle. `locOutValid` stays low, whatever the state of `locOutReady`.
- R4: While a flit addressed to this node waits and `locOutReady` is low, `ringInReady` is low. The flit stays offered on the local output until it is accepted and is never dropped.
- R5: When transit traffic and the queue head both want the ring output, the transit flit is driven on `ringOutData` and the queue is not popped.
- R6: The source queue holds `DEPTH` (default 4) flits. `locInReady` is low exactly when the queue is full.
- R7: With no transit traffic, queued flits leave on the ring output in the order they were injected, one per accepted transfer.
- R8: The response flag (bit `PAY_W`) has no effect on routing. Requests and responses with the same destination take the same path.
- R9: A transit flit stalls the ring input (`ringInReady` low) while `ringOutReady` is low.
- R10: A flit delivered to the local output does not block the ring output. The queue head may leave on the ring in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ringInValid | input | 1 | Upstream ring flit valid |
| ringInReady | output | 1 | Node can take the upstream flit |
| ringInData | input | FLIT_W | Upstream ring flit |
| ringOutValid | output | 1 | Downstream flit valid |
| ringOutReady | input | 1 | Downstream neighbour can take a flit |
| ringOutData | output | FLIT_W | Downstream flit |
| locInValid | input | 1 | Local injection valid |
| locInReady | output | 1 | Source queue has room |
| locInData | input | FLIT_W | Local injection flit |
| locOutValid | output | 1 | Flit for the local device valid |
| locOutReady | input | 1 | Local device can take a flit |
| locOutData | output | FLIT_W | Flit for the local device |

## Verification
The bench targets four corner cases.

- **Queue head and transit together.** A node that let the head win would put the queued word on the ring and lose or delay the transit flit. It would also pop a queue entry that was never sent.
- **Full queue.** A node that ignored a full queue would overwrite the oldest entry, and the drain order would come out wrong.
- **Own flit with a busy local port.** A node that dropped the flit, or kept acknowledging the ring, would let the next upstream flit overwrite it.
- **Delivery and injection in one cycle.** A design that serialised delivery with injection would hold the queue head back during a local delivery.

// File: rtl/ring_node_pkg.sv
package ring_node_pkg;
  localparam int DefIdW    = 3;
  localparam int DefPayW   = 8;
  localparam int DefDepth  = 4;

  // strobes from control to datapath
  typedef struct packed {
    logic fifoPush;   // accept local flit into the source queue
    logic fifoPop;    // queue head leaves on the ring this cycle
    logic selFifo;    // ring output carries the queue head
  } node_strobe_t;
endpackage

// File: rtl/ring_node_ctrl.sv
module ring_node_ctrl
  import ring_node_pkg::*;
(
  input  logic         ringInValid,
  input  logic         destIsMe,
  input  logic         ringOutReady,
  input  logic         locOutReady,
  input  logic         locInValid,
  input  logic         fifoEmpty,
  input  logic         fifoFull,
  output logic         ringInReady,
  output logic         ringOutValid,
  output logic         locOutValid,
  output logic         locInReady,
  output node_strobe_t strobe
);
  logic transit;

  always_comb begin
    transit         = ringInValid && !destIsMe;
    // ring traffic owns the downstream link whenever present
    ringOutValid    = transit || !fifoEmpty;
    locOutValid     = ringInValid && destIsMe;
    ringInReady     = destIsMe ? locOutReady : ringOutReady;
    locInReady      = !fifoFull;
    strobe.selFifo  = !transit;
    strobe.fifoPop  = !transit && !fifoEmpty && ringOutReady;
    strobe.fifoPush = locInValid && !fifoFull;
  end
endmodule

// File: rtl/ring_node_dp.sv
module ring_node_dp
  import ring_node_pkg::*;
#(
  parameter int NODE_ID = 2,
  parameter int ID_W    = DefIdW,
  parameter int PAY_W   = DefPayW,
  parameter int DEPTH   = DefDepth
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ID_W+PAY_W:0] ringInData,
  input  logic [ID_W+PAY_W:0] locInData,
  input  node_strobe_t        strobe,
  output logic [ID_W+PAY_W:0] ringOutData,
  output logic [ID_W+PAY_W:0] locOutData,
  output logic                destIsMe,
  output logic                fifoEmpty,
  output logic                fifoFull
);
  localparam int FLIT_W = ID_W + PAY_W + 1;
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic [FLIT_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  count;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign destIsMe  = (ringInData[FLIT_W-1 -: ID_W] == ID_W'(NODE_ID));
  assign fifoEmpty = (count == '0);
  assign fifoFull  = (count == CNT_W'(DEPTH));

  // one storage word per entry
  for (genvar g = 0; g < DEPTH; g++) begin : gEntry
    always_ff @(posedge clk) begin
      if (strobe.fifoPush && wrPtr == PTR_W'(g)) mem[g] <= locInData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strobe.fifoPush) wrPtr <= bump(wrPtr);
      if (strobe.fifoPop)  rdPtr <= bump(rdPtr);
      case ({strobe.fifoPush, strobe.fifoPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign ringOutData = strobe.selFifo ? mem[rdPtr] : ringInData;
  assign locOutData  = ringInData;
endmodule

// File: rtl/ring_node.sv
module ring_node
  import ring_node_pkg::*;
#(
  parameter int NODE_ID = 2,
  parameter int ID_W    = DefIdW,
  parameter int PAY_W   = DefPayW,
  parameter int DEPTH   = DefDepth,
  localparam int FLIT_W = ID_W + PAY_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ringInValid,
  output logic              ringInReady,
  input  logic [FLIT_W-1:0] ringInData,
  output logic              ringOutValid,
  input  logic              ringOutReady,
  output logic [FLIT_W-1:0] ringOutData,
  input  logic              locInValid,
  output logic              locInReady,
  input  logic [FLIT_W-1:0] locInData,
  output logic              locOutValid,
  input  logic              locOutReady,
  output logic [FLIT_W-1:0] locOutData
);
  node_strobe_t strobe;
  logic destIsMe, fifoEmpty, fifoFull;

  ring_node_ctrl uCtrl (
    .ringInValid (ringInValid),
    .destIsMe    (destIsMe),
    .ringOutReady(ringOutReady),
    .locOutReady (locOutReady),
    .locInValid  (locInValid),
    .fifoEmpty   (fifoEmpty),
    .fifoFull    (fifoFull),
    .ringInReady (ringInReady),
    .ringOutValid(ringOutValid),
    .locOutValid (locOutValid),
    .locInReady  (locInReady),
    .strobe      (strobe)
  );

  ring_node_dp #(
    .NODE_ID(NODE_ID), .ID_W(ID_W), .PAY_W(PAY_W), .DEPTH(DEPTH)
  ) uDp (
    .clk        (clk),
    .rst        (rst),
    .ringInData (ringInData),
    .locInData  (locInData),
    .strobe     (strobe),
    .ringOutData(ringOutData),
    .locOutData (locOutData),
    .destIsMe   (destIsMe),
    .fifoEmpty  (fifoEmpty),
    .fifoFull   (fifoFull)
  );
endmodule

// File: rtl/ring_node_chk.sv
module ring_node_chk #(
  parameter int NODE_ID = 2,
  parameter int ID_W    = 3,
  parameter int PAY_W   = 8,
  parameter int DEPTH   = 4,
  localparam int FLIT_W = ID_W + PAY_W + 1,
  localparam int OCC_W  = $clog2(DEPTH + 1) + 1
) (
  input logic              clk,
  input logic              rst,
  input logic              ringInValid,
  input logic              ringInReady,
  input logic [FLIT_W-1:0] ringInData,
  input logic              ringOutValid,
  input logic              ringOutReady,
  input logic [FLIT_W-1:0] ringOutData,
  input logic              locInValid,
  input logic              locInReady,
  input logic              locOutValid,
  input logic              locOutReady,
  input logic [FLIT_W-1:0] locOutData
);
  logic mine, transitSeen, qPush, qPop;
  logic [OCC_W-1:0] occ;

  assign mine        = ringInData[FLIT_W-1 -: ID_W] == ID_W'(NODE_ID);
  assign transitSeen = ringInValid && !mine;
  assign qPush       = locInValid && locInReady;
  assign qPop        = ringOutValid && ringOutReady && !transitSeen;

  // independent occupancy model built from port handshakes
  always_ff @(posedge clk) begin
    if (rst) occ <= '0;
    else     occ <= occ + OCC_W'(qPush) - OCC_W'(qPop);
  end

  a_r2_own_to_local: assert property (@(posedge clk) disable iff (rst)
    (ringInValid && mine) |-> (locOutValid && locOutData == ringInData));

  a_r3_forward: assert property (@(posedge clk) disable iff (rst)
    transitSeen |-> (ringOutValid && ringOutData == ringInData && !locOutValid));

  a_r4_stall_own: assert property (@(posedge clk) disable iff (rst)
    (ringInValid && mine && !locOutReady) |-> !ringInReady);

  a_r9_stall_transit: assert property (@(posedge clk) disable iff (rst)
    (transitSeen && !ringOutReady) |-> !ringInReady);

  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (occ == OCC_W'(DEPTH)) |-> !locInReady);

  a_r6_occ_bound: assert property (@(posedge clk) disable iff (rst)
    occ <= OCC_W'(DEPTH));

  a_r7_head_offered: assert property (@(posedge clk) disable iff (rst)
    (occ != '0) |-> ringOutValid);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (occ == '0 && !ringInValid) |-> (!ringOutValid && !locOutValid && locInReady));
endmodule

bind ring_node ring_node_chk #(
  .NODE_ID(NODE_ID), .ID_W(ID_W), .PAY_W(PAY_W), .DEPTH(DEPTH)
) uChk (
  .clk         (clk),
  .rst         (rst),
  .ringInValid (ringInValid),
  .ringInReady (ringInReady),
  .ringInData  (ringInData),
  .ringOutValid(ringOutValid),
  .ringOutReady(ringOutReady),
  .ringOutData (ringOutData),
  .locInValid  (locInValid),
  .locInReady  (locInReady),
  .locOutValid (locOutValid),
  .locOutReady (locOutReady),
  .locOutData  (locOutData)
);

// File: tb/ring_node_test.sv
module ring_node_test;
  localparam int FW = 12;  // dest 3 | resp 1 | payload 8, node id 2

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ringInValid = 1'b0, ringOutReady = 1'b0, locInValid = 1'b0, locOutReady = 1'b0;
  logic [FW-1:0] ringInData = '0, locInData = '0;
  logic ringInReady, ringOutValid, locInReady, locOutValid;
  logic [FW-1:0] ringOutData, locOutData;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  ring_node #(.NODE_ID(2), .ID_W(3), .PAY_W(8), .DEPTH(4)) uut (
    .clk(clk), .rst(rst),
    .ringInValid(ringInValid), .ringInReady(ringInReady), .ringInData(ringInData),
    .ringOutValid(ringOutValid), .ringOutReady(ringOutReady), .ringOutData(ringOutData),
    .locInValid(locInValid), .locInReady(locInReady), .locInData(locInData),
    .locOutValid(locOutValid), .locOutReady(locOutReady), .locOutData(locOutData)
  );

  // vector: riV | riD[12] | roR | loR | expRoV | expLoV | expRiR
  localparam logic [17:0] VEC [0:7] = '{
    {1'b1, 12'h45A, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},  // R2 own flit
    {1'b1, 12'h45A, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},  // R4 own, local busy
    {1'b1, 12'hB3C, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},  // R3 transit
    {1'b1, 12'hB3C, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},  // R9 transit stalled
    {1'b1, 12'h577, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},  // R8 own response
    {1'b1, 12'h011, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},  // R3 local busy ignored
    {1'b0, 12'h45A, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},  // R1 idle
    {1'b1, 12'hA3C, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1}   // R8 transit request
  };

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #2;
    chk(ringOutValid, 0, "R1 ringOutValid");
    chk(locOutValid, 0, "R1 locOutValid");
    chk(locInReady, 1, "R1 locInReady");

    // vector table, queue empty, no injection
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      ringInValid  = VEC[i][17];
      ringInData   = VEC[i][16:5];
      ringOutReady = VEC[i][4];
      locOutReady  = VEC[i][3];
      #2;
      chk(ringOutValid, VEC[i][2], $sformatf("vec%0d ringOutValid R2/R3", i));
      chk(locOutValid,  VEC[i][1], $sformatf("vec%0d locOutValid R2/R3", i));
      chk(ringInReady,  VEC[i][0], $sformatf("vec%0d ringInReady R4/R9", i));
      if (VEC[i][2]) chk(ringOutData, VEC[i][16:5], $sformatf("vec%0d ringOutData R3", i));
      if (VEC[i][1]) chk(locOutData,  VEC[i][16:5], $sformatf("vec%0d locOutData R2", i));
    end
    @(negedge clk);
    ringInValid = 1'b0;

    // R6: fill queue with ring output blocked
    ringOutReady = 1'b0;
    for (int k = 0; k < 4; k++) begin
      locInValid = 1'b1;
      locInData  = {3'd5, 1'b0, 8'(8'hA0 + k)};
      #2;
      chk(locInReady, 1, $sformatf("R6 room before push %0d", k));
      @(negedge clk);
    end
    locInValid = 1'b1;
    locInData  = 12'hBEE;
    #2;
    chk(locInReady, 0, "R6 full queue ready");
    @(negedge clk);
    locInValid = 1'b0;

    // R5: transit wins over queue head
    ringInValid  = 1'b1;
    ringInData   = {3'd6, 1'b1, 8'h99};
    ringOutReady = 1'b1;
    #2;
    chk(ringOutData, {3'd6, 1'b1, 8'h99}, "R5 transit on ring output");
    @(negedge clk);
    ringInValid = 1'b0;
    #2;
    chk(ringOutData, {3'd5, 1'b0, 8'hA0}, "R5 head not popped");

    // R7: drain in injection order
    for (int k = 0; k < 4; k++) begin
      #1;
      chk(ringOutValid, 1, $sformatf("R7 valid %0d", k));
      chk(ringOutData, {3'd5, 1'b0, 8'(8'hA0 + k)}, $sformatf("R7 order %0d", k));
      @(negedge clk);
    end
    #2;
    chk(ringOutValid, 0, "R7 empty after drain");
    chk(locInReady, 1, "R6 room after drain");

    // R10: delivery and injection together
    locInValid = 1'b1;
    locInData  = {3'd7, 1'b0, 8'h3D};
    @(negedge clk);
    locInValid  = 1'b0;
    ringInValid = 1'b1;
    ringInData  = {3'd2, 1'b0, 8'h44};
    locOutReady = 1'b1;
    #2;
    chk(locOutValid, 1, "R10 local delivery");
    chk(ringOutValid, 1, "R10 head offered");
    chk(ringOutData, {3'd7, 1'b0, 8'h3D}, "R10 head data");
    @(negedge clk);
    ringInValid = 1'b0;
    #2;
    chk(ringOutValid, 0, "R10 head left");

    // R4: own flit held while local busy
    ringInValid = 1'b1;
    ringInData  = {3'd2, 1'b1, 8'h5C};
    locOutReady = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #2;
      chk(ringInReady, 0, "R4 stall");
      chk(locOutData, {3'd2, 1'b1, 8'h5C}, "R4 held data");
    end
    locOutReady = 1'b1;
    #2;
    chk(ringInReady, 1, "R4 accepted");
    @(negedge clk);
    ringInValid = 1'b0;

    // R1: reset empties a partly filled queue
    ringOutReady = 1'b0;
    locInValid = 1'b1;
    locInData  = 12'hA12;
    repeat (2) @(negedge clk);
    locInValid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #2;
    chk(ringOutValid, 0, "R1 queue cleared");
    chk(locInReady, 1, "R1 ready after reset");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule